// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind a serial-memory front end. It gathers the data bytes of one write transaction into a page buffer of `PAGE_BYTES` slots, one slot per byte of the current page. When chip select rises cleanly at a byte boundary, it copies the gathered bytes into the storage array during a busy interval of fixed length. A separate transaction kind carries an update of the two block-protection bits, and that update is committed in the same way.

The front end signals the start of a transaction with the start address and the kind. It then strobes each received byte, and finally reports the chip-select rise together with a flag that says whether the rise fell right after the last bit of a byte. The engine drops bytes aimed at protected addresses when it latches them. During the busy interval it drives a single-port array write interface, one page slot per cycle. It raises a busy flag for the whole interval and emits a one-cycle pulse at the end, which the front end uses to clear its write-enable latch. The busy length is a clock-cycle parameter, so a short value can stand in for the real millisecond-scale interval.

Top module: `pwb_engine`

## Requirements
- R1: After reset, `wip`, `mem_we`, `bp_we` and `wel_clear` are all 0.
- R2: Data bytes are latched at successive offsets from the low 4 bits of `txn_addr`. The offset wraps from 15 to 0, and the upper address bits (7:4) stay fixed, so every committed write stays inside one 16-byte page.
- R3: When more than 16 bytes arrive, a byte that lands on an offset already filled in this transaction replaces the earlier one, and only the latest value is committed.
- R4: A commit starts only when `cs_rise` arrives with `cs_aligned`=1, `wel`=1 and `wp_n`=1. Otherwise the transaction ends with the array unchanged and `wip` stays 0.
- R5: A transaction with no byte strobes produces no busy interval and no `wel_clear` pulse.
- R6: `wip` is 1 for exactly `BUSY_CYC` cycles, starting the cycle after the qualifying `cs_rise`. `mem_we` is asserted only while `wip` is 1.
- R7: `wel_clear` pulses once, in the last cycle of the busy interval, and `wip` is 0 in the next cycle.
- R8: Protection level `bp_level` 00 protects nothing, 01 protects C0h-FFh, 10 protects 80h-FFh and 11 protects the whole array. Bytes aimed at protected addresses are not written, but the busy interval still runs.
- R9: Page locations that got no byte in the transaction keep their previous contents.
- R10: For a status transaction (`txn_status`=1), the commit pulses `bp_we` once, in the first busy cycle, with `bp_wdata` equal to bits 3:2 of the last byte received. No array write occurs.
- R11: While `wip` is 1, `txn_start`, `byte_vld` and `cs_rise` have no effect: the busy length is unchanged and no second commit follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Opens a transaction (pulse) |
| txn_status | input | 1 | 1 = protection-bit update, 0 = array write |
| txn_addr | input | ADDR_W | Start address of the array write |
| byte_vld | input | 1 | One received data byte (pulse) |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip select rose (pulse) |
| cs_aligned | input | 1 | The rise came right after a byte's last bit |
| bp_level | input | 2 | Current block-protection level |
| wp_n | input | 1 | Write-protect level, 0 blocks commits |
| wel | input | 1 | Write-enable latch state |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| bp_we | output | 1 | Protection-bit write strobe |
| bp_wdata | output | 2 | New protection level |
| wip | output | 1 | Busy interval in progress |
| wel_clear | output | 1 | End-of-busy pulse that clears the write-enable latch |

## Verification
The bench sweeps single-byte writes across every protection level at the addresses just inside and just outside each protection boundary. A wrong threshold would show up as a corrupted protected byte or a missing unprotected one. Page writes that start mid-page and run past 16 bytes catch a counter that carries into the next page or keeps a stale first-pass byte. Partial writes catch a design that writes the whole page back over unreceived slots. Misaligned, unenabled, write-protected and empty transactions must leave `wip` low and the array intact, and stimulus injected during the busy interval must neither stretch it nor start a second one.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef struct packed {
        logic is_status;
        logic any_rx;
    } txn_ctl_t;

    // Returns 1 when addr falls in the region guarded by protection level bp.
    function automatic logic prot_hit(input int addr, input int addr_w, input logic [1:0] bp);
        int top;
        int thr;
        top = 1 << addr_w;
        case (bp)
            2'b00:   thr = top;
            2'b01:   thr = top - top / 4;
            2'b10:   thr = top / 2;
            default: thr = 0;
        endcase
        return addr >= thr;
    endfunction

endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
    parameter int PAGE_BYTES = 16,
    parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [OFS_W-1:0] ofs_in,
    input  logic             wr,
    input  logic             drop,
    input  logic [7:0]       wdata,
    input  logic [OFS_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_vld,
    output logic [OFS_W-1:0] cur_ofs
);

    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;

    // In-page offset: wraps naturally inside the page.
    always_ff @(posedge clk) begin
        if (rst)        cur_ofs <= '0;
        else if (clear) cur_ofs <= ofs_in;
        else if (wr)    cur_ofs <= cur_ofs + 1'b1;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                filled[g] <= 1'b0;
            end else if (wr && !drop && cur_ofs == OFS_W'(g)) begin
                filled[g] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (wr && !drop && cur_ofs == OFS_W'(g)) slot[g] <= wdata;
        end
    end

    assign rd_data = slot[rd_idx];
    assign rd_vld  = filled[rd_idx];

    AST_DROP_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
        wr && drop && !clear |=> $stable(filled)); // R8

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int BUSY_CYC = 40,
    parameter int CW       = $clog2(BUSY_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    output logic          busy,
    output logic          last,
    output logic [CW-1:0] cnt
);

    assign last = busy && (cnt == CW'(BUSY_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      cnt  <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt < CW'(BUSY_CYC)); // R6

endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int BUSY_CYC   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic              txn_status,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic [1:0]        bp_level,
    input  logic              wp_n,
    input  logic              wel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              bp_we,
    output logic [1:0]        bp_wdata,
    output logic              wip,
    output logic              wel_clear
);

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CW     = $clog2(BUSY_CYC + 1);

    txn_ctl_t          ctl;
    logic              collecting;
    logic [PAGE_W-1:0] page;
    logic [1:0]        stat_bp;
    logic              busy, last;
    logic [CW-1:0]     cnt;
    logic [OFS_W-1:0]  cur_ofs;
    logic [7:0]        rd_data;
    logic              rd_vld;
    logic              start_ok, accept, go, drop;

    assign start_ok = txn_start && !busy;
    assign accept   = collecting && !busy && byte_vld && !txn_start;
    assign go       = collecting && !busy && cs_rise && cs_aligned
                      && ctl.any_rx && wel && wp_n;
    assign drop     = ctl.is_status
                      || prot_hit(int'({page, cur_ofs}), ADDR_W, bp_level);

    always_ff @(posedge clk) begin
        if (rst) begin
            collecting <= 1'b0;
            ctl        <= '0;
            page       <= '0;
            stat_bp    <= '0;
        end else if (start_ok) begin
            collecting    <= 1'b1;
            ctl.is_status <= txn_status;
            ctl.any_rx    <= 1'b0;
            page          <= txn_addr[ADDR_W-1:OFS_W];
        end else if (!busy) begin
            if (accept) begin
                ctl.any_rx <= 1'b1;
                if (ctl.is_status) stat_bp <= byte_data[3:2];
            end
            if (cs_rise) collecting <= 1'b0;
        end
    end

    pwb_latch #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .ofs_in  (txn_addr[OFS_W-1:0]),
        .wr      (accept),
        .drop    (drop),
        .wdata   (byte_data),
        .rd_idx  (cnt[OFS_W-1:0]),
        .rd_data (rd_data),
        .rd_vld  (rd_vld),
        .cur_ofs (cur_ofs)
    );

    pwb_timer #(.BUSY_CYC(BUSY_CYC), .CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .busy (busy),
        .last (last),
        .cnt  (cnt)
    );

    // Sweep the page slots in the first PAGE_BYTES busy cycles.
    assign mem_we    = busy && !ctl.is_status && (cnt < CW'(PAGE_BYTES)) && rd_vld;
    assign mem_addr  = {page, cnt[OFS_W-1:0]};
    assign mem_wdata = rd_data;
    assign bp_we     = busy && ctl.is_status && (cnt == '0);
    assign bp_wdata  = stat_bp;
    assign wip       = busy;
    assign wel_clear = last;

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wip); // R6
    AST_CLEAR_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        wel_clear |=> !wip); // R7
    AST_FALL_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> $past(wel_clear)); // R7
    AST_ABORT_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_rise && !cs_aligned && !wip |=> !wip); // R4
    AST_STATUS_NO_ARRAY: assert property (@(posedge clk) disable iff (rst)
        bp_we |-> !mem_we); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wip && !wel_clear |=> wip); // R11

endmodule

// File: tb/pwb_engine_tb.sv
module pwb_engine_tb;

    localparam int BC = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txn_start = 0, txn_status = 0;
    logic [7:0] txn_addr = 0;
    logic       byte_vld = 0;
    logic [7:0] byte_data = 0;
    logic       cs_rise = 0, cs_aligned = 0;
    logic [1:0] bp_level = 0;
    logic       wp_n = 1, wel = 1;
    logic       mem_we, bp_we, wip, wel_clear;
    logic [7:0] mem_addr, mem_wdata;
    logic [1:0] bp_wdata;

    int n_run = 0, n_fail = 0;
    logic [7:0] bmem [256];
    logic [7:0] emem [256];

    always #2.5 clk = ~clk;

    pwb_engine #(.ADDR_W(8), .PAGE_BYTES(16), .BUSY_CYC(BC)) u_dut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_status(txn_status),
        .txn_addr(txn_addr), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .bp_level(bp_level),
        .wp_n(wp_n), .wel(wel), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .bp_we(bp_we), .bp_wdata(bp_wdata),
        .wip(wip), .wel_clear(wel_clear)
    );

    always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic is_prot(input int a, input int bp);
        int thr;
        thr = (bp == 0) ? 256 : (bp == 1) ? 192 : (bp == 2) ? 128 : 0;
        return a >= thr;
    endfunction

    task automatic cmp_array(input string tag);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (bmem[i] !== emem[i] && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, {tag, " array byte"}, int'(bmem[bad]), int'(emem[bad]));
    endtask

    task automatic run_txn(input string tag, input logic st, input int addr, input int n,
                           input int seed, input logic al, input logic we_l, input logic wp_l,
                           input int bp, input logic inject);
        int wc = 0, cc = 0, bc = 0;
        logic [1:0] bv = 0;
        logic commit;
        commit = al && we_l && wp_l && (n > 0);
        @(negedge clk);
        bp_level = 2'(bp); wel = we_l; wp_n = wp_l;
        txn_start = 1; txn_status = st; txn_addr = 8'(addr);
        @(negedge clk); txn_start = 0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1; byte_data = dval(seed, i);
            @(negedge clk);
        end
        byte_vld = 0;
        cs_rise = 1; cs_aligned = al;
        @(negedge clk); cs_rise = 0; cs_aligned = 0;
        for (int k = 0; k < BC + 6; k++) begin
            if (wip) wc++;
            if (wel_clear) begin
                cc++;
                if (wip !== 1'b1) chk(1'b0, {tag, " R7 clear outside busy"}, 0, 1);
            end
            if (bp_we) begin bc++; bv = bp_wdata; end
            if (inject && k == 3) begin
                txn_start = 1; txn_status = 0; txn_addr = 8'h00;
                byte_vld = 1; byte_data = 8'h5A; cs_rise = 1; cs_aligned = 1;
            end else begin
                txn_start = 0; byte_vld = 0; cs_rise = 0; cs_aligned = 0;
            end
            @(negedge clk);
        end
        if (commit && !st)
            for (int i = 0; i < n; i++) begin
                int a;
                a = (addr & 8'hF0) | ((addr + i) & 15);
                if (!is_prot(a, bp)) emem[a] = dval(seed, i);
            end
        chk(wc == (commit ? BC : 0), {tag, " R6 busy length"}, wc, commit ? BC : 0);
        chk(cc == (commit ? 1 : 0), {tag, " R7 clear pulses"}, cc, commit ? 1 : 0);
        if (st) begin
            chk(bc == (commit ? 1 : 0), {tag, " R10 bp_we pulses"}, bc, commit ? 1 : 0);
            if (commit) chk(bv == dval(seed, n - 1)[3:2], {tag, " R10 bp value"},
                            int'(bv), int'(dval(seed, n - 1)[3:2]));
        end
        cmp_array(tag);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'(i) ^ 8'hA5;
            emem[i] = 8'(i) ^ 8'hA5;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(wip == 0 && mem_we == 0 && bp_we == 0 && wel_clear == 0, "R1 reset outputs",
            int'({wip, mem_we, bp_we, wel_clear}), 0);

        // R8: protection sweep at region boundaries
        for (int bp = 0; bp < 4; bp++) begin
            int adr [8] = '{8'h00, 8'h3F, 8'h40, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
            for (int j = 0; j < 8; j++)
                run_txn($sformatf("R8 bp=%0d a=%0h", bp, adr[j]), 0, adr[j], 1,
                        bp * 8 + j, 1, 1, 1, bp, 0);
        end
        // R2: full page from mid-page, wrapping inside the page
        run_txn("R2 page wrap 0x25", 0, 8'h25, 16, 101, 1, 1, 1, 0, 0);
        run_txn("R2 page wrap 0x3F", 0, 8'h3F, 3, 102, 1, 1, 1, 0, 0);
        // R3: overrun, later bytes replace earlier ones
        run_txn("R3 overrun 20 bytes", 0, 8'h4A, 20, 103, 1, 1, 1, 0, 0);
        // R9: partial page leaves other slots intact
        run_txn("R9 partial 5 bytes", 0, 8'h13, 5, 104, 1, 1, 1, 0, 0);
        // R4: aborts
        run_txn("R4 misaligned rise", 0, 8'h60, 4, 105, 0, 1, 1, 0, 0);
        run_txn("R4 latch not set", 0, 8'h60, 4, 106, 1, 0, 1, 0, 0);
        run_txn("R4 write-protect low", 0, 8'h60, 4, 107, 1, 1, 0, 0, 0);
        // R5: no data bytes
        run_txn("R5 empty write", 0, 8'h70, 0, 108, 1, 1, 1, 0, 0);
        run_txn("R5 empty status", 1, 8'h00, 0, 109, 1, 1, 1, 0, 0);
        // R10: status commits
        run_txn("R10 status one byte", 1, 8'h00, 1, 110, 1, 1, 1, 0, 0);
        run_txn("R10 status two bytes", 1, 8'h00, 2, 111, 1, 1, 1, 3, 0);
        run_txn("R10 status misaligned", 1, 8'h00, 1, 112, 0, 1, 1, 0, 0);
        // R11: stimulus during busy is ignored
        run_txn("R11 inject during busy", 0, 8'h90, 6, 113, 1, 1, 1, 0, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule